// File: doc/BRIEF.md
# OSD Character Line Pixel Serializer

This block turns one line of a stored on-screen-display character glyph into a stream of 2-bit overlay codes, one pixel per clock enable. A glyph is 18 lines of 12 pixels. Each line is held as three packed bytes, and each byte carries four 2-bit pixels. A start strobe captures one line together with the character's attributes. The block then shifts the 12 pixels out, leftmost first. Each pixel goes out on a cycle where the pixel enable is high.

Each raw pixel is decoded into black, white or transparent. A per-character invert attribute swaps black and white. A per-character blink attribute blanks the whole line to transparent while the captured blink phase is off. A valid pulse marks each emitted pixel, a last flag marks the twelfth, and a busy flag covers the run.

Top module: `osd_line_serializer`

## Requirements
- R1: After reset, busy, pix_valid and pix_last are 0 and pix_code is 01 (transparent).
- R2: A start strobe seen while idle with line_idx below 18 is accepted, and busy is 1 from the following cycle.
- R3: A start strobe with line_idx of 18 or more is ignored: busy stays 0 and no pixel is produced.
- R4: An accepted line produces exactly 12 pixels. Bits [23:16] of line_bytes come first and bits [7:0] last, and within a byte bits [7:6] come first and bits [1:0] last.
- R5: pix_last is 1 together with the twelfth pixel only, and busy is 0 in that same cycle.
- R6: Raw pixel 00 is output as 00 (black), 10 as 10 (white), and both 01 and 11 as 01 (transparent). Code 11 never appears on pix_code.
- R7: With inv set at start, black and white are swapped (00 gives 10, 10 gives 00), and transparent pixels stay 01.
- R8: With blink set and blink_on 0 at start, every pixel of the line is 01. With blink_on 1, or with blink clear, pixels decode as in R6 and R7.
- R9: A start strobe that arrives while busy is ignored, and the current run continues unchanged.
- R10: A pixel is emitted, one cycle after a clock edge at which pix_en is 1 and the block is busy. When pix_en is 0, pix_valid is 0 and the run does not advance.
- R11: line_bytes, inv, blink and blink_on are captured at start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel clock enable |
| start | input | 1 | Start strobe for one glyph line |
| line_idx | input | 5 | Glyph line index, valid range 0 to 17 |
| line_bytes | input | 24 | Three packed pixel bytes of the line |
| inv | input | 1 | Invert attribute of the character |
| blink | input | 1 | Blink enable of the character |
| blink_on | input | 1 | Blink phase, 1 means visible |
| pix_valid | output | 1 | One-cycle pulse per emitted pixel |
| pix_code | output | 2 | Pixel code: 00 black, 10 white, 01 transparent |
| pix_last | output | 1 | Marks the twelfth pixel of the line |
| busy | output | 1 | A line is being serialized |

## Verification
On every cycle, the assertions check the following properties. A run never has more or fewer than twelve valid pulses, and the last flag lands on the twelfth. Busy drops together with the last flag. Code 11 never leaves the block. A valid pulse only follows an enabled, busy edge. A start is accepted or refused according to the line index.

The bit order of the pixels and the decoded value of each pixel can only be shown by the bench's scoreboard. The same is true of the effects of invert and blink phase. The scoreboard compares each pixel against codes computed from the line bytes. The scenarios also show that a start issued mid-run is ignored, and that attribute changes after capture are ignored. Both are seen as an unchanged pixel sequence.

// File: rtl/osd_ser_pkg.sv
package osd_ser_pkg;
    parameter int PIX_W          = 2;
    parameter int PIX_PER_BYTE   = 4;
    parameter int BYTES_PER_LINE = 3;
    parameter int GLYPH_LINES    = 18;

    localparam int PIX_PER_LINE = PIX_PER_BYTE * BYTES_PER_LINE;
    localparam int LINE_BITS    = PIX_W * PIX_PER_LINE;
    localparam int CNT_W        = $clog2(PIX_PER_LINE);
    localparam int LINE_W       = $clog2(GLYPH_LINES);

    typedef enum logic [PIX_W-1:0] {
        PIX_BLACK = 2'b00,
        PIX_TRANS = 2'b01,
        PIX_WHITE = 2'b10
    } pix_code_e;
endpackage

// File: rtl/osd_pix_decode.sv
module osd_pix_decode
    import osd_ser_pkg::*;
(
    input  logic [PIX_W-1:0] raw_pix,
    input  logic             invert,
    input  logic             blank,
    output logic [PIX_W-1:0] code
);
    always_comb begin
        if (blank) begin
            code = PIX_TRANS;
        end else begin
            unique case (raw_pix)
                PIX_BLACK: code = invert ? PIX_WHITE : PIX_BLACK;
                PIX_WHITE: code = invert ? PIX_BLACK : PIX_WHITE;
                default:   code = PIX_TRANS;
            endcase
        end
    end
endmodule

// File: rtl/osd_ser_ctrl.sv
module osd_ser_ctrl
    import osd_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_en,
    input  logic                 start,
    input  logic [LINE_W-1:0]    line_idx,
    input  logic [LINE_BITS-1:0] line_bytes,
    input  logic                 inv,
    input  logic                 blink,
    input  logic                 blink_on,
    input  logic [PIX_W-1:0]     dec_code,
    output logic [PIX_W-1:0]     cur_pix,
    output logic                 cur_inv,
    output logic                 cur_blank,
    output logic                 pix_valid,
    output logic [PIX_W-1:0]     pix_code,
    output logic                 pix_last,
    output logic                 busy
);
    typedef struct packed {
        logic                 busy;
        logic [LINE_BITS-1:0] sr;
        logic [CNT_W-1:0]     cnt;
        logic                 inv;
        logic                 blank;
        logic                 valid;
        logic [PIX_W-1:0]     code;
        logic                 last;
    } ser_state_t;

    localparam logic [CNT_W-1:0]  LAST_IDX  = CNT_W'(PIX_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LINE_LIM  = LINE_W'(GLYPH_LINES);

    ser_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        if (!st_q.busy) begin
            if (start && (line_idx < LINE_LIM)) begin
                st_d.busy  = 1'b1;
                st_d.sr    = line_bytes;
                st_d.cnt   = '0;
                st_d.inv   = inv;
                st_d.blank = blink & ~blink_on;
            end
        end else if (pix_en) begin
            st_d.valid = 1'b1;
            st_d.code  = dec_code;
            st_d.sr    = st_q.sr << PIX_W;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) begin
                st_d.last = 1'b1;
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, sr: '0, cnt: '0, inv: 1'b0, blank: 1'b0,
                      valid: 1'b0, code: PIX_TRANS, last: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_pix   = st_q.sr[LINE_BITS-1 -: PIX_W];
    assign cur_inv   = st_q.inv;
    assign cur_blank = st_q.blank;
    assign pix_valid = st_q.valid;
    assign pix_code  = st_q.code;
    assign pix_last  = st_q.last;
    assign busy      = st_q.busy;
endmodule

// File: rtl/osd_line_serializer.sv
module osd_line_serializer
    import osd_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_en,
    input  logic                 start,
    input  logic [LINE_W-1:0]    line_idx,
    input  logic [LINE_BITS-1:0] line_bytes,
    input  logic                 inv,
    input  logic                 blink,
    input  logic                 blink_on,
    output logic                 pix_valid,
    output logic [PIX_W-1:0]     pix_code,
    output logic                 pix_last,
    output logic                 busy
);
    logic [PIX_W-1:0] cur_pix;
    logic [PIX_W-1:0] dec_code;
    logic             cur_inv;
    logic             cur_blank;

    osd_pix_decode u_dec (
        .raw_pix (cur_pix),
        .invert  (cur_inv),
        .blank   (cur_blank),
        .code    (dec_code)
    );

    osd_ser_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .start      (start),
        .line_idx   (line_idx),
        .line_bytes (line_bytes),
        .inv        (inv),
        .blink      (blink),
        .blink_on   (blink_on),
        .dec_code   (dec_code),
        .cur_pix    (cur_pix),
        .cur_inv    (cur_inv),
        .cur_blank  (cur_blank),
        .pix_valid  (pix_valid),
        .pix_code   (pix_code),
        .pix_last   (pix_last),
        .busy       (busy)
    );
endmodule

// File: rtl/osd_ser_checker.sv
module osd_ser_checker
    import osd_ser_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              start,
    input logic [LINE_W-1:0] line_idx,
    input logic              pix_valid,
    input logic [PIX_W-1:0]  pix_code,
    input logic              pix_last,
    input logic              busy
);
    localparam logic [LINE_W-1:0] LINE_LIM = LINE_W'(GLYPH_LINES);
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(PIX_PER_LINE - 1);

    logic [CNT_W-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                vcnt <= '0;
        else if (pix_valid) begin
            if (pix_last)          vcnt <= '0;
            else                   vcnt <= vcnt + 1'b1;
        end
    end

    a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |-> (vcnt == LAST_IDX));
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_last) |-> (vcnt < LAST_IDX));
    a_r5_last_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |-> (pix_valid && !busy));
    a_r6_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_code != 2'b11));
    a_r10_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ($past(pix_en) && $past(busy)));
    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (line_idx < LINE_LIM)) |=> busy);
    a_r3_bad_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (line_idx >= LINE_LIM)) |=> !busy);
endmodule

bind osd_line_serializer osd_ser_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .start     (start),
    .line_idx  (line_idx),
    .pix_valid (pix_valid),
    .pix_code  (pix_code),
    .pix_last  (pix_last),
    .busy      (busy)
);

// File: tb/tb_osd_line_serializer.sv
`timescale 1ns/1ps
module tb_osd_line_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  line_idx = '0;
    logic [23:0] line_bytes = '0;
    logic        inv = 1'b0;
    logic        blink = 1'b0;
    logic        blink_on = 1'b0;
    logic        pix_valid;
    logic [1:0]  pix_code;
    logic        pix_last;
    logic        busy;

    always #2 clk = ~clk;

    osd_line_serializer dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start(start),
        .line_idx(line_idx), .line_bytes(line_bytes), .inv(inv),
        .blink(blink), .blink_on(blink_on), .pix_valid(pix_valid),
        .pix_code(pix_code), .pix_last(pix_last), .busy(busy)
    );

    typedef struct {
        logic [1:0] code;
        logic       last;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [1:0] p, input logic iv,
                                         input logic bk, input logic ph);
        if (bk && !ph)     return 2'b01;
        if (p == 2'b00)    return iv ? 2'b10 : 2'b00;
        if (p == 2'b10)    return iv ? 2'b00 : 2'b10;
        return 2'b01;
    endfunction

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor
    initial begin
        forever begin
            logic en_s, busy_s;
            exp_t e;
            @(posedge clk);
            en_s = pix_en;
            busy_s = busy;
            #1;
            if (rst_n && pix_valid) begin
                check(en_s && busy_s, "R10 valid without enabled busy edge", int'(en_s), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected pixel", int'(pix_code), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(pix_code == e.code, e.tag, int'(pix_code), int'(e.code));
                    check(pix_last == e.last, "R5 last flag", int'(pix_last), int'(e.last));
                    if (pix_last)
                        check(!busy, "R5 busy clears with last", int'(busy), 0);
                end
            end
        end
    end

    // mess: 0 none, 1 change inputs after start (R11), 2 restart mid-run (R9)
    task automatic run_line(input logic [4:0] li, input logic [23:0] bytes,
                            input logic iv, input logic bk, input logic ph,
                            input bit alt_en, input int mess, input string tag);
        exp_t e;
        int step = 0;
        for (int i = 0; i < 12; i++) begin
            e.code = model(bytes[23-2*i -: 2], iv, bk, ph);
            e.last = (i == 11);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b1; line_idx = li; line_bytes = bytes;
        inv = iv; blink = bk; blink_on = ph; pix_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R2 busy after accepted start", int'(busy), 1);
        while (busy) begin
            pix_en = alt_en ? ~pix_en : 1'b1;
            if (mess == 1) begin
                inv = ~inv; blink_on = ~blink_on; blink = ~blink; line_bytes = ~line_bytes;
            end
            if (mess == 2) begin
                start = (step == 3 || step == 6);
                line_idx = 5'd0; line_bytes = 24'hFFFFFF;
            end
            step++;
            @(negedge clk);
        end
        start = 1'b0;
        pix_en = 1'b0;
        check(exp_q.size() == 0, {tag, " R4 twelve pixels"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic bad_line(input logic [4:0] li);
        @(negedge clk);
        start = 1'b1; line_idx = li; line_bytes = 24'h123456; pix_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R3 bad line stays idle", int'(busy), 0);
        @(negedge clk);
        check(!pix_valid && !busy, "R3 no pixel for bad line", int'(pix_valid), 0);
        pix_en = 1'b0;
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 reset busy", int'(busy), 0);
        check(!pix_valid, "R1 reset valid", int'(pix_valid), 0);
        check(!pix_last, "R1 reset last", int'(pix_last), 0);
        check(pix_code == 2'b01, "R1 reset code", int'(pix_code), 1);

        // order and decode: 00 10 01 11 | 10 00 11 01 | 00 00 10 10
        run_line(5'd0, 24'b00100111_10001101_00001010, 0, 0, 0, 0, 0, "R4 R6 order decode");
        run_line(5'd5, 24'b00100111_10001101_00001010, 1, 0, 0, 0, 0, "R7 invert");
        run_line(5'd6, 24'b10101010_00000000_01011111, 0, 1, 0, 0, 0, "R8 blink off");
        run_line(5'd7, 24'b10101010_00000000_01011111, 1, 1, 1, 0, 0, "R8 blink on");
        run_line(5'd8, 24'b10001000_11100100_00011011, 0, 0, 0, 0, 0, "R8 no blink ignores phase");
        run_line(5'd9, 24'b11100100_00011011_10100000, 0, 0, 1, 1, 0, "R10 gated enable");
        run_line(5'd10, 24'b00101000_10000010_01100001, 1, 0, 1, 0, 1, "R11 captured attributes");
        run_line(5'd11, 24'b10100000_01010000_00001010, 0, 0, 1, 0, 2, "R9 start while busy");
        run_line(5'd17, 24'hA5C30F, 0, 0, 1, 1, 0, "R2 last legal line");
        bad_line(5'd18);
        bad_line(5'd31);
        run_line(5'd1, 24'h28A082, 0, 0, 1, 0, 0, "R4 after refused starts");
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule